// File: doc/BRIEF.md
# Prefixed Instruction Byte Decoder

The decoder takes a stream of 8-bit instruction components and turns each complete instruction into one decoded record. Every component carries a 4-bit function code in its upper nibble and a 4-bit data nibble in its lower nibble. Two function codes are prefixes: they add their nibble to a 32-bit operand accumulator and shift it up by four bits, so an operand of any width can be built four bits at a time. The positive prefix shifts the value unchanged. The negative prefix complements the whole word before the shift, which produces negative operands.

Any other function code ends the instruction. The decoder presents the function code together with the final operand. For function 15 the final value is instead reported as a secondary operation code, with an operate flag raised. The accumulator then returns to zero. A saturating count of the prefixes that built the instruction comes out alongside, for diagnostic checking.

Components enter through a valid/ready handshake. The decoded record is shown for exactly one cycle, with a valid pulse. There is no backpressure on the output. Instead, the input stalls during that single presentation cycle.

The controller has three states:
- `ST_IDLE`: the accumulator is zero and no prefix is pending.
- `ST_PREFIX`: one or more prefixes have been absorbed.
- `ST_EMIT`: the decoded record is on the outputs and input is refused.

It has five transitions:
- IDLE→PREFIX on an accepted prefix.
- PREFIX→PREFIX on a further accepted prefix.
- IDLE→EMIT on an accepted completing component.
- PREFIX→EMIT on an accepted completing component.
- EMIT→IDLE unconditionally after one cycle.

With no accepted component, IDLE and PREFIX hold.

Top module: `pfx_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and `out_operand`, `out_func` and `out_prefix_cnt` are 0.
- R2: A component's function code is bits 7..4 and its data nibble is bits 3..0. A completing component with no prior prefix gives `out_func` = bits 7..4 and `out_operand` = the nibble zero-extended (0x4A gives function 4, operand 10).
- R3: A positive prefix (function 2) places its nibble in bits 3..0 of the accumulator, then shifts the accumulator left by 4. The pair 0x21, 0x41 gives function 4 with operand 17.
- R4: A negative prefix (function 6) places its nibble in bits 3..0, complements all 32 bits, then shifts left by 4. The pair 0x6F, 0x40 gives operand -256, and the pair 0x60, 0x4F gives operand -1.
- R5: A completing component with function 15 raises `out_is_opr`, and `out_operand` carries the secondary operation code built the same way. 0xF5 gives code 5, and 0x24, 0xF6 gives code 70. Every other completing function leaves `out_is_opr` at 0.
- R6: After a completing component the accumulator restarts at zero, so the next instruction's operand does not depend on earlier ones.
- R7: `out_valid` is high for exactly one cycle, the cycle after the completing component is accepted. Prefix components produce no output pulse.
- R8: `in_ready` is low exactly in the cycle in which `out_valid` is high, and high otherwise.
- R9: `out_prefix_cnt` reports the number of prefixes in the decoded instruction, saturating at 8.
- R10: A component held valid while `in_ready` is low is not consumed; it is consumed exactly once, in the first cycle `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Component byte is offered |
| in_ready | output | 1 | Decoder can take a component this cycle |
| in_byte | input | 8 | Component: function code in 7..4, data nibble in 3..0 |
| out_valid | output | 1 | Single-cycle pulse: decoded record is valid |
| out_is_opr | output | 1 | Record is a secondary operation (function 15) |
| out_func | output | 4 | Function code of the completing component |
| out_operand | output | 32 | Final operand, or secondary operation code when `out_is_opr` is set |
| out_prefix_cnt | output | 4 | Prefixes in this instruction, saturating at 8 |

## Verification
Some behaviours are checked by assertions on every cycle:
- The one-cycle output pulse, and that it follows an accepted input.
- The exact coupling of the stalled input to the pulse.
- That the reported function code matches the completing byte and is never a prefix code.
- That the operate flag follows function 15.
- The prefix-count ceiling, and the operand of an unprefixed instruction.

The arithmetic of long mixed positive and negative prefix chains can only be shown by the bench scenarios. The same holds for the clearing of the accumulator between instructions and for exactly-once consumption of a byte held across the stall. The bench compares these against its own reference model.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREFIX = 2'd1,
        ST_EMIT   = 2'd2
    } dec_state_e;

    typedef enum logic [1:0] {
        STEP_POS  = 2'd0,
        STEP_NEG  = 2'd1,
        STEP_DONE = 2'd2
    } step_kind_e;

    localparam int          NIB_W       = 4;
    localparam int          COMP_W      = 2 * NIB_W;
    localparam logic [3:0]  FN_POS_PFX  = 4'h2;
    localparam logic [3:0]  FN_NEG_PFX  = 4'h6;
    localparam logic [3:0]  FN_OPERATE  = 4'hF;

endpackage

// File: rtl/pfx_operand_step.sv
module pfx_operand_step
    import pfx_dec_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [COMP_W-1:0] comp_byte,
    output step_kind_e        kind,
    output logic [WORD_W-1:0] loaded,
    output logic [WORD_W-1:0] next_acc
);

    logic [NIB_W-1:0] func;
    logic [NIB_W-1:0] nib;

    assign func   = comp_byte[COMP_W-1:NIB_W];
    assign nib    = comp_byte[NIB_W-1:0];
    assign loaded = {acc[WORD_W-1:NIB_W], nib};

    always_comb begin
        unique case (func)
            FN_POS_PFX: begin
                kind     = STEP_POS;
                next_acc = loaded << NIB_W;
            end
            FN_NEG_PFX: begin
                kind     = STEP_NEG;
                next_acc = (~loaded) << NIB_W;
            end
            default: begin
                kind     = STEP_DONE;
                next_acc = '0;
            end
        endcase
    end

endmodule

// File: rtl/pfx_count_sat.sv
module pfx_count_sat #(
    parameter int CNT_MAX = 8,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && (count != LIMIT)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
    import pfx_dec_pkg::*;
#(
    parameter  int WORD_W  = 32,
    parameter  int CNT_MAX = 8,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic              out_is_opr,
    output logic [3:0]        out_func,
    output logic [WORD_W-1:0] out_operand,
    output logic [CNT_W-1:0]  out_prefix_cnt
);

    dec_state_e        state_q, state_d;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] step_loaded;
    logic [WORD_W-1:0] step_next;
    step_kind_e        step_kind;
    logic              accept;
    logic              completes;
    logic [CNT_W-1:0]  pfx_cnt;

    assign in_ready  = (state_q != ST_EMIT);
    assign accept    = in_valid && in_ready;
    assign completes = accept && (step_kind == STEP_DONE);

    pfx_operand_step #(.WORD_W(WORD_W)) u_step (
        .acc       (acc_q),
        .comp_byte (in_byte),
        .kind      (step_kind),
        .loaded    (step_loaded),
        .next_acc  (step_next)
    );

    pfx_count_sat #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (completes),
        .inc   (accept && (step_kind != STEP_DONE)),
        .count (pfx_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PREFIX: begin
                if (accept) begin
                    state_d = (step_kind == STEP_DONE) ? ST_EMIT : ST_PREFIX;
                end
            end
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and operand accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                acc_q <= completes ? '0 : step_next;
            end
        end
    end

    // Output record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_is_opr     <= 1'b0;
            out_func       <= '0;
            out_operand    <= '0;
            out_prefix_cnt <= '0;
        end else begin
            out_valid <= completes;
            if (completes) begin
                out_func       <= in_byte[7:4];
                out_is_opr     <= (in_byte[7:4] == FN_OPERATE);
                out_operand    <= step_loaded;
                out_prefix_cnt <= pfx_cnt;
            end
        end
    end

endmodule

// File: rtl/pfx_decoder_chk.sv
module pfx_decoder_chk #(
    parameter int WORD_W  = 32,
    parameter int CNT_MAX = 8,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        in_byte,
    input logic              out_valid,
    input logic              out_is_opr,
    input logic [3:0]        out_func,
    input logic [WORD_W-1:0] out_operand,
    input logic [CNT_W-1:0]  out_prefix_cnt
);

    // R7: output pulse lasts one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: every pulse follows an accepted component
    p_pulse_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));

    // R8: input refused exactly while a record is shown
    p_ready_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == !in_ready);

    // R2: reported function code is the completing byte's upper nibble
    p_func_from_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_func == $past(in_byte[7:4]));

    // R2: unprefixed operand is the zero-extended nibble
    p_plain_operand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prefix_cnt == '0) |->
            (out_operand[WORD_W-1:4] == '0 && out_operand[3:0] == $past(in_byte[3:0])));

    // R3: prefix codes never complete an instruction
    p_no_prefix_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_func != 4'h2 && out_func != 4'h6));

    // R5: operate flag tracks function 15
    p_opr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_is_opr == ($past(in_byte[7:4]) == 4'hF)));

    // R9: prefix count never exceeds its ceiling
    p_cnt_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_prefix_cnt <= CNT_W'(CNT_MAX));

endmodule

bind pfx_decoder pfx_decoder_chk #(
    .WORD_W  (WORD_W),
    .CNT_MAX (CNT_MAX),
    .CNT_W   (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_byte        (in_byte),
    .out_valid      (out_valid),
    .out_is_opr     (out_is_opr),
    .out_func       (out_func),
    .out_operand    (out_operand),
    .out_prefix_cnt (out_prefix_cnt)
);

// File: tb/pfx_decoder_bench.sv
`timescale 1ns/1ps
module pfx_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_is_opr;
    logic [3:0]  out_func;
    logic [31:0] out_operand;
    logic [3:0]  out_prefix_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_acc = 32'h0;
    int          m_cnt = 0;

    always #10 clk = ~clk;

    pfx_decoder u_pfx_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_byte        (in_byte),
        .out_valid      (out_valid),
        .out_is_opr     (out_is_opr),
        .out_func       (out_func),
        .out_operand    (out_operand),
        .out_prefix_cnt (out_prefix_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] with_nib(input logic [31:0] acc, input logic [7:0] b);
        return {acc[31:4], b[3:0]};
    endfunction

    function automatic logic [31:0] after_prefix(input logic [31:0] acc, input logic [7:0] b);
        logic [31:0] v = with_nib(acc, b);
        if (b[7:4] == 4'h6) v = ~v;
        return v << 4;
    endfunction

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic send(input logic [7:0] b);
        logic [31:0] exp_op;
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) begin
            @(negedge clk);
            chk("R7 pulse ends after one cycle", out_valid, 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (b[7:4] == 4'h2 || b[7:4] == 4'h6) begin
            m_acc = after_prefix(m_acc, b);
            if (m_cnt < 8) m_cnt++;
            chk("R7 no pulse on prefix", out_valid, 0);
            chk("R8 ready while accumulating", in_ready, 1);
        end else begin
            exp_op = with_nib(m_acc, b);
            chk("R7 pulse after completion", out_valid, 1);
            chk("R8 ready low with pulse", in_ready, 0);
            chk("R2 function code", out_func, b[7:4]);
            chk("R5 operate flag", out_is_opr, (b[7:4] == 4'hF));
            chk("R3 R4 operand value", out_operand, exp_op);
            chk("R9 prefix count", out_prefix_cnt, m_cnt);
            m_acc = 32'h0;
            m_cnt = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_instr();
        int          np;
        logic [3:0]  f;
        np = $urandom_range(0, 10);
        for (int i = 0; i < np; i++) begin
            send({($urandom_range(0, 1) == 1) ? 4'h2 : 4'h6, 4'($urandom)});
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        do f = 4'($urandom); while (f == 4'h2 || f == 4'h6);
        send({f, 4'($urandom)});
        if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    endtask

    initial begin
        void'($urandom(32'h5EED_0420));
        idle(3);
        // R1: reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 operand", out_operand, 0);
        chk("R1 func", out_func, 0);
        chk("R1 count", out_prefix_cnt, 0);
        rst_n = 1'b1;
        idle(1);

        // R2: plain component
        send(8'h4A);
        chk("R2 operand 10", out_operand, 32'd10);
        // R3: positive prefix
        send(8'h21); send(8'h41);
        chk("R3 operand 17", out_operand, 32'd17);
        // R4: negative prefix
        send(8'h6F); send(8'h40);
        chk("R4 operand -256", out_operand, 32'hFFFF_FF00);
        send(8'h60); send(8'h4F);
        chk("R4 operand -1", out_operand, 32'hFFFF_FFFF);
        // R5: operate
        send(8'hF5);
        chk("R5 opcode 5", out_operand, 32'd5);
        chk("R5 flag set", out_is_opr, 1);
        send(8'h24); send(8'hF6);
        chk("R5 opcode 70", out_operand, 32'd70);
        // R9: saturation with ten prefixes
        for (int i = 0; i < 10; i++) send(8'h2F);
        send(8'h10);
        chk("R9 saturated at 8", out_prefix_cnt, 4'd8);
        // R6: accumulator cleared
        send(8'h43);
        chk("R6 fresh operand", out_operand, 32'd3);
        chk("R6 count cleared", out_prefix_cnt, 0);
        // R10: back-to-back bytes held across the stall
        send(8'h2A); send(8'h7B); send(8'h7C); send(8'h65); send(8'hF1);
        chk("R10 held byte consumed once", out_operand, 32'hFFFF_FFA1);

        for (int k = 0; k < 300; k++) rand_instr();

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule